// File: doc/BRIEF.md
# Pulse-Density Polar Carrier Modulator

This block turns a polar baseband sample into a one-bit switching waveform for a class-D output stage. A fast tick clock provides the time resolution that a chain of delay cells would otherwise give. The carrier is a fixed 50% square wave whose rising edge is pushed later in time by the phase code. The envelope code does not touch the carrier duty. It sets how long a gate stays open at the start of each intermediate-frequency (IF) frame. The output is the carrier ANDed with that gate, so a larger envelope lets more carrier pulses through per frame.

Carrier and IF periods are given in ticks on configuration inputs. A sample strobe captures a phase and envelope word into a pending holder. The running frame takes its words only at a frame boundary, so a frame never mixes two samples. Configurations that break the timing rules raise an error flag, and the output stays low while the flag is set. A synchronous enable starts both period counters from zero, and the output goes low once the enable is removed.

Top module: `ifpd_modulator`

## Requirements
- R1: While reset is high, and in the first cycles after it with enable low, `tx_out` and `cfg_err` are 0.
- R2: The phase code is 8 bits and splits the carrier period into 256 equal steps of `car_period/256` ticks. If enable is sampled high at edge k, `tx_out` after edge k+1+n shows tick n. Within each carrier period the carrier rises at tick position `phase_in*car_period/256`.
- R3: The carrier is high for exactly `car_period/2` ticks of every carrier period. No output pulse lasts longer than that.
- R4: The envelope code is 7 bits. The gate is open for the first `env_in*if_period/128` ticks of every IF frame. A code of 0 keeps the output low for the whole frame.
- R5: `tx_out` is high for a tick exactly when the phase-shifted carrier and the envelope gate are both high.
- R6: `cfg_err` is 1 when `car_period` is 0 or not a multiple of 256, or when `if_period` is 0 or not a multiple of 128.
- R7: `cfg_err` is 1 when the carrier-to-IF frequency ratio is a multiple of one half, that is when `2*if_period` is an exact multiple of `car_period`.
- R8: `cfg_err` is 1 when `if_period < 10*car_period`. This guarantees that a gate for any envelope above a tenth of full scale is at least one carrier period long.
- R9: A word taken by `smp_stb` is applied from the next IF frame boundary onward. The frame in progress keeps its earlier words.
- R10: After enable is sampled low, `tx_out` is 0 from the second following edge onward. A new enable restarts the carrier and IF counts from tick 0.
- R11: While `cfg_err` is 1, `tx_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Synchronous run enable |
| car_period | input | CNT_W | Carrier period in ticks |
| if_period | input | CNT_W | IF frame period in ticks |
| smp_stb | input | 1 | Captures phase_in and env_in into the pending holder |
| phase_in | input | PH_W | Quantized phase, 256 steps per carrier period |
| env_in | input | ENV_W | Quantized envelope, 128 levels per IF frame |
| tx_out | output | 1 | Modulated one-bit carrier, registered |
| cfg_err | output | 1 | Configuration fault flag, registered |

## Verification
The bench builds the block with its default widths: 16-bit period counters, an 8-bit phase code and a 7-bit envelope code. Those widths allow carrier periods of 512 and 768 ticks, which give phase steps of two and three ticks and make non-unit step scaling visible. They also allow IF frames of 5248 and 7808 ticks, which pass the ratio and fill rules while keeping several complete frames short enough to compare tick by tick against a model. The same widths reach each fault class in turn: a misaligned carrier, a misaligned frame, a half-integer period ratio, and a frame too short for the fill rule.

// File: rtl/ifpd_pkg.sv
package ifpd_pkg;

  typedef struct packed {
    logic align;   // a period is zero or not a multiple of its step count
    logic ratio;   // carrier/IF frequency ratio is a multiple of one half
    logic fill;    // IF frame too short to pass a whole carrier period
  } cfg_fault_t;

endpackage

// File: rtl/ifpd_cfg_check.sv
module ifpd_cfg_check #(
  parameter int CNT_W    = 16,
  parameter int PH_W     = 8,
  parameter int ENV_W    = 7,
  parameter int MIN_FILL = 10
) (
  input  logic [CNT_W-1:0]     car_period,
  input  logic [CNT_W-1:0]     if_period,
  output ifpd_pkg::cfg_fault_t fault
);

  localparam int XW = CNT_W + 8;

  logic [CNT_W:0]   twice_if;
  logic [CNT_W:0]   car_div;
  logic [CNT_W:0]   rem;
  logic [XW-1:0]    fill_need;

  always_comb begin
    fault.align = (car_period == '0) || (if_period == '0) ||
                  (car_period[PH_W-1:0] != '0) ||
                  (if_period[ENV_W-1:0] != '0);
    car_div     = (car_period == '0) ? (CNT_W+1)'(1) : {1'b0, car_period};
    twice_if    = {if_period, 1'b0};
    rem         = twice_if % car_div;
    fault.ratio = (rem == '0);
    fill_need   = XW'(car_period) * XW'(MIN_FILL);
    fault.fill  = fill_need > XW'(if_period);
  end

endmodule

// File: rtl/ifpd_timebase.sv
module ifpd_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] car_period,
  input  logic [CNT_W-1:0] if_period,
  output logic [CNT_W-1:0] car_cnt,
  output logic [CNT_W-1:0] if_cnt,
  output logic             load
);

  logic car_wrap;
  logic if_wrap;

  assign car_wrap = (car_cnt == car_period - 1'b1);
  assign if_wrap  = (if_cnt == if_period - 1'b1);
  assign load     = !run || if_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      car_cnt <= '0;
      if_cnt  <= '0;
    end else begin
      car_cnt <= car_wrap ? '0 : car_cnt + 1'b1;
      if_cnt  <= if_wrap  ? '0 : if_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ifpd_word_latch.sv
module ifpd_word_latch #(
  parameter int PH_W  = 8,
  parameter int ENV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic [PH_W-1:0]  phase_in,
  input  logic [ENV_W-1:0] env_in,
  input  logic             load,
  output logic [PH_W-1:0]  act_ph,
  output logic [ENV_W-1:0] act_env
);

  logic [PH_W-1:0]  pend_ph;
  logic [ENV_W-1:0] pend_env;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_ph  <= '0;
      pend_env <= '0;
      act_ph   <= '0;
      act_env  <= '0;
    end else begin
      if (smp_stb) begin
        pend_ph  <= phase_in;
        pend_env <= env_in;
      end
      if (load) begin
        act_ph  <= pend_ph;
        act_env <= pend_env;
      end
    end
  end

  AST_HOLD_MID_FRAME: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(act_ph) && $stable(act_env))); // R9

endmodule

// File: rtl/ifpd_shaper.sv
module ifpd_shaper #(
  parameter int CNT_W = 16,
  parameter int PH_W  = 8,
  parameter int ENV_W = 7
) (
  input  logic [CNT_W-1:0] car_cnt,
  input  logic [CNT_W-1:0] if_cnt,
  input  logic [CNT_W-1:0] car_period,
  input  logic [CNT_W-1:0] if_period,
  input  logic [PH_W-1:0]  act_ph,
  input  logic [ENV_W-1:0] act_env,
  output logic             car_ref,
  output logic             gate
);

  logic [CNT_W-1:0] ph_unit;
  logic [CNT_W-1:0] env_unit;
  logic [CNT_W-1:0] lag;
  logic [CNT_W-1:0] shifted;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] open_len;

  always_comb begin
    ph_unit  = car_period >> PH_W;
    env_unit = if_period >> ENV_W;
    half     = car_period >> 1;
    lag      = {{(CNT_W-PH_W){1'b0}}, act_ph} * ph_unit;
    if (car_cnt >= lag) shifted = car_cnt - lag;
    else                shifted = car_cnt + car_period - lag;
    car_ref  = shifted < half;
    open_len = {{(CNT_W-ENV_W){1'b0}}, act_env} * env_unit;
    gate     = if_cnt < open_len;
  end

endmodule

// File: rtl/ifpd_modulator.sv
module ifpd_modulator #(
  parameter int CNT_W    = 16,
  parameter int PH_W     = 8,
  parameter int ENV_W    = 7,
  parameter int MIN_FILL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] car_period,
  input  logic [CNT_W-1:0] if_period,
  input  logic             smp_stb,
  input  logic [PH_W-1:0]  phase_in,
  input  logic [ENV_W-1:0] env_in,
  output logic             tx_out,
  output logic             cfg_err
);

  ifpd_pkg::cfg_fault_t fault;
  logic             err_c;
  logic             run_q;
  logic [CNT_W-1:0] car_cnt;
  logic [CNT_W-1:0] if_cnt;
  logic             load;
  logic [PH_W-1:0]  act_ph;
  logic [ENV_W-1:0] act_env;
  logic             car_ref;
  logic             gate;
  logic [CNT_W-1:0] hi_run;

  ifpd_cfg_check #(.CNT_W(CNT_W), .PH_W(PH_W), .ENV_W(ENV_W), .MIN_FILL(MIN_FILL)) chk_i (
    .car_period(car_period), .if_period(if_period), .fault(fault));

  assign err_c = |fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      run_q   <= en && !err_c;
      cfg_err <= err_c;
    end
  end

  ifpd_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst(rst), .run(run_q), .car_period(car_period), .if_period(if_period),
    .car_cnt(car_cnt), .if_cnt(if_cnt), .load(load));

  ifpd_word_latch #(.PH_W(PH_W), .ENV_W(ENV_W)) lat_i (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .phase_in(phase_in), .env_in(env_in),
    .load(load), .act_ph(act_ph), .act_env(act_env));

  ifpd_shaper #(.CNT_W(CNT_W), .PH_W(PH_W), .ENV_W(ENV_W)) shp_i (
    .car_cnt(car_cnt), .if_cnt(if_cnt), .car_period(car_period), .if_period(if_period),
    .act_ph(act_ph), .act_env(act_env), .car_ref(car_ref), .gate(gate));

  always_ff @(posedge clk) begin
    if (rst) tx_out <= 1'b0;
    else     tx_out <= run_q && car_ref && gate;
  end

  // Length of the current high stretch on the output, for the width check.
  always_ff @(posedge clk) begin
    if (rst)         hi_run <= '0;
    else if (tx_out) hi_run <= hi_run + 1'b1;
    else             hi_run <= '0;
  end

  AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst)
    hi_run <= (car_period >> 1)); // R3
  AST_ZERO_ENV_LOW: assert property (@(posedge clk) disable iff (rst)
    (run_q && act_env == '0) |=> !tx_out); // R4
  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |-> ##2 !tx_out); // R10
  AST_ERR_LOW: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !tx_out); // R11

endmodule

// File: tb/ifpd_modulator_tb_top.sv
module ifpd_modulator_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] car_period = 16'd512;
  logic [15:0] if_period = 16'd5248;
  logic        smp_stb = 1'b0;
  logic [7:0]  phase_in = '0;
  logic [6:0]  env_in = '0;
  logic        tx_out;
  logic        cfg_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  ifpd_modulator dut_i (
    .clk(clk), .rst(rst), .en(en), .car_period(car_period), .if_period(if_period),
    .smp_stb(smp_stb), .phase_in(phase_in), .env_in(env_in),
    .tx_out(tx_out), .cfg_err(cfg_err));

  // {car_period, if_period, phase, envelope, ticks}
  localparam logic [63:0] VEC [6] = '{
    {16'd512, 16'd5248, 8'd0,   8'd64,  16'd8000},
    {16'd512, 16'd5248, 8'd100, 8'd127, 16'd6000},
    {16'd512, 16'd5248, 8'd255, 8'd13,  16'd6000},
    {16'd768, 16'd7808, 8'd37,  8'd90,  16'd9000},
    {16'd512, 16'd5248, 8'd64,  8'd0,   16'd5300},
    {16'd768, 16'd7808, 8'd200, 8'd1,   16'd8000}
  };

  function automatic bit model(int n, int car, int ifp, int ph, int env);
    int cp, ip, lag, sh;
    cp  = n % car;
    ip  = n % ifp;
    lag = ph * (car / 256);
    sh  = (cp - lag + car) % car;
    return (sh < car / 2) && (ip < env * (ifp / 128));
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic run_seq(input int car, input int ifp, input int ph, input int env,
                         input int len, input int chg, input int ph2, input int env2,
                         input string tag);
    int bad = 0;
    int bad_n = 0;
    int bad_e = 0;
    en = 1'b0;
    repeat (3) @(negedge clk);
    car_period = 16'(car); if_period = 16'(ifp);
    phase_in = 8'(ph); env_in = 7'(env); smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; en = 1'b1;
    @(negedge clk);
    for (int n = 0; n < len; n++) begin
      bit e;
      @(negedge clk);
      if (n == chg) begin
        phase_in = 8'(ph2); env_in = 7'(env2); smp_stb = 1'b1;
      end else smp_stb = 1'b0;
      if (chg >= 0 && (n / ifp) >= 1) e = model(n, car, ifp, ph2, env2);
      else                             e = model(n, car, ifp, ph, env);
      if (tx_out !== e) begin
        if (bad == 0) begin bad_n = n; bad_e = int'(e); end
        bad++;
      end
    end
    check(bad == 0, {tag, " waveform (first bad tick in next line if any)"},
          bad == 0 ? 0 : int'(!bad_e), bad_e);
    if (bad != 0) $display("  tick %0d, %0d mismatching ticks", bad_n, bad);
    check(cfg_err == 1'b0, {tag, " cfg_err clear for valid setup"}, int'(cfg_err), 0);
  endtask

  task automatic err_case(input int car, input int ifp, input string tag);
    int highs = 0;
    en = 1'b0;
    repeat (3) @(negedge clk);
    car_period = 16'(car); if_period = 16'(ifp);
    phase_in = 8'd0; env_in = 7'd127; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    check(cfg_err == 1'b1, {tag, " cfg_err raised"}, int'(cfg_err), 1);
    repeat (40) begin
      @(negedge clk);
      if (tx_out) highs++;
    end
    check(highs == 0, {tag, " R11 output held low under fault"}, highs, 0);
  endtask

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    check(tx_out == 1'b0 && cfg_err == 1'b0, "R1 outputs low in reset",
          int'({tx_out, cfg_err}), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_out == 1'b0 && cfg_err == 1'b0, "R1 outputs low after reset",
          int'({tx_out, cfg_err}), 0);

    // R2 R3 R4 R5 R10: vector table, each run restarting from tick 0
    for (int i = 0; i < 6; i++) begin
      run_seq(int'(VEC[i][63:48]), int'(VEC[i][47:32]), int'(VEC[i][31:24]),
              int'(VEC[i][23:16]), int'(VEC[i][15:0]), -1, 0, 0,
              $sformatf("R2 R3 R4 R5 vector %0d", i));
    end

    // R9: new words strobed mid-frame take effect at the next boundary
    run_seq(512, 5248, 0, 64, 2 * 5248 + 200, 1000, 128, 20, "R9 boundary latch");

    // R10: dropping enable while the output is high
    en = 1'b0;
    repeat (3) @(negedge clk);
    car_period = 16'd512; if_period = 16'd5248;
    phase_in = 8'd0; env_in = 7'd127; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; en = 1'b1;
    repeat (12) @(negedge clk);
    check(tx_out == 1'b1, "R10 output high before disable", int'(tx_out), 1);
    en = 1'b0;
    @(negedge clk);
    begin
      int highs = 0;
      repeat (20) begin
        @(negedge clk);
        if (tx_out) highs++;
      end
      check(highs == 0, "R10 output low after disable", highs, 0);
    end

    // Fault classes
    err_case(300, 5248, "R6 carrier not multiple of 256");
    err_case(512, 5000, "R6 frame not multiple of 128");
    err_case(512, 5376, "R7 half-integer ratio");
    err_case(1024, 5248, "R8 frame shorter than fill rule");

    // Recovery after a fault with a valid setup
    run_seq(512, 5248, 17, 40, 600, -1, 0, 0, "R6 R7 R8 recovery");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule